// File: doc/BRIEF.md
# Congestion-Aware Fork with Bypass Merge

This block is a routing junction for a stream of data elements. Each accepted element is stamped with an incrementing sequence tag. It is then steered into one of two delay pipelines that compute the same result. The primary pipeline is used whenever its entry is free. When an external block signal holds the primary entry, the element takes the bypass pipeline instead. The two pipelines may have different lengths.

The outputs of both pipelines join at a merge point. When both present an element in the same cycle, the merge takes the primary one first. Merged elements are written into a small reorder buffer at the slot given by their tag. The buffer releases them strictly in tag order on a valid/ready output. The buffer depth also bounds the number of elements in flight, and the input stalls once that bound is reached.

The pipelines carry data unchanged and stand in for the duplicated computation. DEPTH must be a power of two.

Top module: `bypass_fork_merge`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: With prim_block_i low, an element accepted at a rising edge goes down the primary path. With an otherwise empty block and out_ready_i high, out_valid_o rises after the PRIM_LAT-th following rising edge, with out_data_o equal to the accepted in_data_i.
- R3: With prim_block_i high, an accepted element goes down the bypass path. With an otherwise empty block, out_valid_o rises after the BYP_LAT-th following rising edge, with the data unchanged.
- R4: At most DEPTH elements are in flight. Once DEPTH elements have been accepted and none released, in_ready_o is 0.
- R5: Under arbitrary stalls on the primary entry, the input and the output, every accepted element appears on the output exactly once, in the order of acceptance.
- R6: When both pipelines present an element in the same cycle, the primary one is merged first. The bypass element is held and merged later without loss.
- R7: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input element valid |
| in_ready_o | output | 1 | Input element accepted when high with in_valid_i |
| in_data_i | input | DW | Input element data |
| prim_block_i | input | 1 | Primary path entry obstructed |
| out_valid_o | output | 1 | Output element valid |
| out_ready_i | input | 1 | Output consumer ready |
| out_data_o | output | DW | Output element data, in input order |

## Verification
A primary-path element is written to the reorder buffer PRIM_LAT rising edges after the edge that accepts it. A bypass element is written BYP_LAT edges after its accepting edge. In both cases out_valid_o is then visible at the next falling edge. The bench drives and samples only at falling edges. For each single-element vector it counts the falling edges after acceptance and expects the first valid one at count LAT+1. In the random phase, the bench decides which handshakes happen from the levels it sees just after the falling edge. Those levels hold through the following rising edge. So each transfer is credited to exactly one cycle, and held outputs are compared one cycle later.

// File: rtl/bfm_pkg.sv
`timescale 1ns/1ps
package bfm_pkg;
  typedef enum logic {ROUTE_PRI = 1'b0, ROUTE_BYP = 1'b1} route_e;

  localparam int unsigned DEF_DW    = 16;
  localparam int unsigned DEF_DEPTH = 8;
endpackage

// File: rtl/bfm_pipe.sv
`timescale 1ns/1ps
module bfm_pipe #(
  parameter int unsigned W   = 16,
  parameter int unsigned LAT = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         v_q [LAT];
  logic [W-1:0] d_q [LAT];
  logic         adv;

  // whole pipe moves unless the last stage is stuck
  assign adv         = !v_q[LAT-1] || out_ready_i;
  assign in_ready_o  = adv && !hold_i;
  assign out_valid_o = v_q[LAT-1];
  assign out_data_o  = d_q[LAT-1];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[0] <= 1'b0;
          d_q[0] <= '0;
        end else if (adv) begin
          v_q[0] <= in_valid_i && in_ready_o;
          d_q[0] <= in_data_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[i] <= 1'b0;
          d_q[i] <= '0;
        end else if (adv) begin
          v_q[i] <= v_q[i-1];
          d_q[i] <= d_q[i-1];
        end
      end
    end
  end

  a_r7_pipe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

// File: rtl/bfm_rob.sv
`timescale 1ns/1ps
module bfm_rob #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned TW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [W-1:0]  out_data_o
);
  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     mem_q [DEPTH];
  logic [TW-1:0]    head_q;
  logic             pop;

  assign out_valid_o = vld_q[head_q];
  assign out_data_o  = mem_q[head_q];
  assign pop         = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      head_q <= '0;
    end else begin
      if (wr_en_i) vld_q[wr_tag_i] <= 1'b1;
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_tag_i] <= wr_data_i;
  end

  a_r5_slot_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !vld_q[wr_tag_i]);
  a_r5_head_retires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> !vld_q[$past(head_q)] || $past(wr_en_i && wr_tag_i == head_q));
endmodule

// File: rtl/bypass_fork_merge.sv
`timescale 1ns/1ps
module bypass_fork_merge
  import bfm_pkg::*;
#(
  parameter int unsigned DW       = DEF_DW,
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned PRIM_LAT = 4,
  parameter int unsigned BYP_LAT  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  input  logic          prim_block_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  localparam int unsigned TW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned PW = TW + DW;

  logic [TW-1:0] tag_q;
  logic [CW-1:0] inflight_q;
  logic          credit_ok, in_fire, out_fire;
  route_e        route;

  logic          prim_in_rdy, prim_in_vld, prim_ov;
  logic          byp_in_rdy, byp_in_vld, byp_ov, byp_or;
  logic [PW-1:0] prim_od, byp_od, entry;

  logic          rob_wr;
  logic [PW-1:0] rob_sel;

  // fork
  assign credit_ok   = inflight_q < CW'(DEPTH);
  assign route       = prim_in_rdy ? ROUTE_PRI : ROUTE_BYP;
  assign in_ready_o  = credit_ok && (prim_in_rdy || byp_in_rdy);
  assign in_fire     = in_valid_i && in_ready_o;
  assign prim_in_vld = in_fire && (route == ROUTE_PRI);
  assign byp_in_vld  = in_fire && (route == ROUTE_BYP);
  assign entry       = {tag_q, in_data_i};
  assign out_fire    = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q      <= '0;
      inflight_q <= '0;
    end else begin
      if (in_fire) tag_q <= tag_q + 1'b1;
      case ({in_fire, out_fire})
        2'b10:   inflight_q <= inflight_q + 1'b1;
        2'b01:   inflight_q <= inflight_q - 1'b1;
        default: inflight_q <= inflight_q;
      endcase
    end
  end

  bfm_pipe #(.W(PW), .LAT(PRIM_LAT)) u_prim (
    .clk_i, .rst_ni,
    .hold_i     (prim_block_i),
    .in_valid_i (prim_in_vld),
    .in_ready_o (prim_in_rdy),
    .in_data_i  (entry),
    .out_valid_o(prim_ov),
    .out_ready_i(1'b1),
    .out_data_o (prim_od)
  );

  bfm_pipe #(.W(PW), .LAT(BYP_LAT)) u_byp (
    .clk_i, .rst_ni,
    .hold_i     (1'b0),
    .in_valid_i (byp_in_vld),
    .in_ready_o (byp_in_rdy),
    .in_data_i  (entry),
    .out_valid_o(byp_ov),
    .out_ready_i(byp_or),
    .out_data_o (byp_od)
  );

  // merge: fixed priority to primary
  assign byp_or  = !prim_ov;
  assign rob_wr  = prim_ov || byp_ov;
  assign rob_sel = prim_ov ? prim_od : byp_od;

  bfm_rob #(.W(DW), .DEPTH(DEPTH)) u_rob (
    .clk_i, .rst_ni,
    .wr_en_i    (rob_wr),
    .wr_tag_i   (rob_sel[PW-1:DW]),
    .wr_data_i  (rob_sel[DW-1:0]),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (out_data_o)
  );

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(DEPTH));
  a_r4_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q == CW'(DEPTH) |-> !in_ready_o);
  a_r3_blocked_to_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire && prim_block_i |-> byp_in_vld && !prim_in_vld);
  a_r2_free_to_primary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire && !prim_block_i |-> prim_in_vld);
  a_r6_bypass_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_ov && byp_ov |=> byp_ov && $stable(byp_od));
  a_r7_out_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

// File: tb/bypass_fork_merge_bench.sv
`timescale 1ns/1ps
module bypass_fork_merge_bench;
  localparam int DW = 16, DEPTH = 8, PRIM_LAT = 4, BYP_LAT = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          in_valid = 1'b0, prim_block = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid;
  logic [DW-1:0] out_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bypass_fork_merge #(.DW(DW), .DEPTH(DEPTH), .PRIM_LAT(PRIM_LAT), .BYP_LAT(BYP_LAT))
  u_bypass_fork_merge (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .prim_block_i(prim_block),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // {prim_block, data}
  localparam logic [DW:0] VEC [6] = '{
    {1'b0, 16'h1234}, {1'b1, 16'hbeef}, {1'b0, 16'h0001},
    {1'b1, 16'hffff}, {1'b1, 16'h0a0a}, {1'b0, 16'h8000}
  };

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tx = 0, rx = 0;
    bit prev_stall = 1'b0;
    logic [DW-1:0] prev_data = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R2 / R3 latency vectors
    foreach (VEC[k]) begin
      int cnt;
      int exp_lat;
      exp_lat = VEC[k][DW] ? BYP_LAT : PRIM_LAT;
      @(negedge clk);
      prim_block = VEC[k][DW];
      in_data    = VEC[k][DW-1:0];
      in_valid   = 1'b1;
      out_ready  = 1'b1;
      #1;
      chk(in_ready == 1'b1, VEC[k][DW] ? "R3" : "R2", "in_ready idle", int'(in_ready), 1);
      @(negedge clk);
      in_valid = 1'b0;
      prim_block = 1'b0;
      cnt = 1;
      while (!out_valid && cnt < 20) begin
        @(negedge clk);
        cnt++;
      end
      chk(cnt == exp_lat + 1, VEC[k][DW] ? "R3" : "R2", "latency", cnt, exp_lat + 1);
      chk(out_data == VEC[k][DW-1:0], VEC[k][DW] ? "R3" : "R2", "data",
          int'(out_data), int'(VEC[k][DW-1:0]));
      repeat (2) @(negedge clk);
    end

    // R4: fill with output stalled
    out_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(16'h100 + i);
      #1;
      chk(in_ready == 1'b1, "R4", "in_ready before full", int'(in_ready), 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (PRIM_LAT + 2) @(negedge clk);
    chk(in_ready == 1'b0, "R4", "in_ready when full", int'(in_ready), 0);
    chk(out_valid == 1'b1, "R7", "held valid", int'(out_valid), 1);
    chk(out_data == 16'h100, "R7", "held data", int'(out_data), 16'h100);
    out_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk(out_valid && out_data == DW'(16'h100 + i), "R4", "drain order",
          int'(out_data), 16'h100 + i);
      @(negedge clk);
    end
    chk(in_ready == 1'b1, "R4", "in_ready after drain", int'(in_ready), 1);

    // R5 / R6 / R7: random stalls, order and completeness
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (c < 2400) begin
        in_valid   = 1'($urandom_range(0, 1));
        prim_block = ($urandom_range(0, 2) == 0);
        out_ready  = ($urandom_range(0, 3) != 0);
      end else begin
        in_valid   = 1'b0;
        prim_block = 1'b0;
        out_ready  = 1'b1;
      end
      in_data = DW'(tx);
      #1;
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R7", "stall hold",
            int'(out_data), int'(prev_data));
      if (out_valid && out_ready) begin
        chk(out_data == DW'(rx), "R5", "order", int'(out_data), rx);
        rx++;
      end
      if (in_valid && in_ready) tx++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
    chk(rx == tx, "R5", "all delivered once (R6 no loss)", rx, tx);
    chk(out_valid == 1'b0, "R5", "no extra output", int'(out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule